// File: doc/BRIEF.md
# Masked Change Interrupt Generator

This block watches a row of general-purpose input pins and a small set of PWM channels, some of which may be routed onto those pins. When an unmasked source changes level, rising or falling, the block sets a status bit for that pin. The bit stays set until software reads the status. The active-low interrupt line is low while any status bit is set and the interrupt function is enabled.

Pins that are not driven by a PWM take their level from a two-flop synchroniser. A pin can instead be routed to one PWM channel. Such a pin only reports the toggles of that channel, and only when the channel runs from the slowest of its clock sources.

A read strobe returns the status vector in the same cycle and clears it at the following clock edge. A change detected in that same cycle is not lost: it appears in the next read.

Top module: `mcig_top`

## Requirements
- R1: A level change, in either direction, on an unmasked pin that is not routed to a PWM sets that pin's bit in `stat_rdata` at the third rising clock edge after the new level is applied to `gpio_in`.
- R2: While a pin's `int_mask` bit is 1, no change on that pin, from any source, sets its status bit.
- R3: When `pin_pwm_en[p]` is 1, pin p follows PWM channel `pin_pwm_sel[p*SEL_W +: SEL_W]`. A toggle of that channel sets bit p at the first rising edge, provided the channel's 3-bit `pwm_clk_src` field (channel w at bits `[3w+2:3w]`) holds the slowest-source code 3'd4. Level changes on `gpio_in[p]` are then ignored.
- R4: A toggle of a PWM channel whose clock-source code is not 3'd4 never sets a status bit.
- R5: A set status bit stays set, with no further activity, until a status read.
- R6: While `stat_rd` is high, `stat_rdata` shows the current status bits. At the next edge the read bits clear. A change detected in the read cycle sets its bit anyway, and that bit shows in the next read.
- R7: `irq_n` is 0 exactly when `irq_en` is 1 and at least one status bit is set. Clearing `irq_en` raises `irq_n` but leaves the status bits unchanged.
- R8: After `rst_n` has been held low for at least three cycles, all status bits are 0 and `irq_n` is 1. Input levels present when reset is released are not counted as changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gpio_in | input | N_PIN | Asynchronous pin levels |
| int_mask | input | N_PIN | 1 suppresses the pin as an interrupt source |
| pin_pwm_en | input | N_PIN | 1 routes the pin to a PWM channel |
| pin_pwm_sel | input | N_PIN*SEL_W | PWM channel index for each pin |
| pwm_out | input | N_PWM | PWM channel outputs, synchronous to clk |
| pwm_clk_src | input | N_PWM*3 | Clock-source code per channel; 3'd4 is the slowest |
| irq_en | input | 1 | Interrupt output enable |
| stat_rd | input | 1 | Status read strobe |
| stat_rdata | output | N_PIN | Latched status bits |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A pin level reaches the status bits three edges after it is driven: two synchroniser flops and one edge-detect register. A PWM toggle reaches them one edge after it is driven. `stat_rdata` and `irq_n` follow the status register with no added delay. The bench drives every input on the falling edge and samples on falling edges. For pin stimulus it checks that the bit is still clear after two edges and set after the third. Read data is sampled inside the strobe cycle, before the clearing edge, and the cleared state is checked on the next falling edge.

// File: rtl/mcig_pkg.sv
// Shared definitions for the masked change interrupt generator.
// Assumes a 3-bit clock-source code per PWM channel.
package mcig_pkg;
    localparam int CLK_SRC_W = 3;

    typedef enum logic [CLK_SRC_W-1:0] {
        SRC_32K   = 3'd0,
        SRC_24M   = 3'd1,
        SRC_1M5   = 3'd2,
        SRC_94K   = 3'd3,
        SRC_SLOW  = 3'd4,
        SRC_CHAIN = 3'd5
    } clk_src_e;
endpackage

// File: rtl/mcig_sync2.sv
// Two-flop synchroniser for asynchronous pin levels.
// Assumes the inputs are level signals that are not reset. The flops
// settle while the block is held in reset.
module mcig_sync2 #(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Two-stage capture of the raw pin levels.
    always_ff @(posedge clk) begin
        meta <= d;
        q    <= meta;
    end
endmodule

// File: rtl/mcig_change_detect.sv
// Chooses the change source for each pin, either the synchronised GPIO
// level or one PWM channel, and produces masked change pulses.
// Assumes pwm_out is synchronous to clk. The previous-level registers
// track their inputs at all times, including reset, so the levels
// present at reset release are never seen as changes.
module mcig_change_detect
    import mcig_pkg::*;
#(
    parameter int N_PIN = 20,
    parameter int N_PWM = 4,
    parameter int SEL_W = 2
) (
    input  logic                   clk,
    input  logic [N_PIN-1:0]       gpio_s,
    input  logic [N_PIN-1:0]       int_mask,
    input  logic [N_PIN-1:0]       pin_pwm_en,
    input  logic [N_PIN*SEL_W-1:0] pin_pwm_sel,
    input  logic [N_PWM-1:0]       pwm_out,
    input  logic [N_PWM*CLK_SRC_W-1:0] pwm_clk_src,
    output logic [N_PIN-1:0]       evt
);
    logic [N_PIN-1:0] gpio_prev;
    logic [N_PWM-1:0] pwm_prev;
    logic [N_PWM-1:0] pwm_chg;

    // Hold the previous levels so that edges can be detected.
    always_ff @(posedge clk) begin
        gpio_prev <= gpio_s;
        pwm_prev  <= pwm_out;
    end

    // A PWM toggle is a source only when the channel runs from the slowest clock.
    for (genvar w = 0; w < N_PWM; w++) begin : g_pwm
        assign pwm_chg[w] = (pwm_out[w] ^ pwm_prev[w]) &&
                            (pwm_clk_src[w*CLK_SRC_W +: CLK_SRC_W] == SRC_SLOW);
    end

    // Per pin: pick the change source, then apply the mask.
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        logic [SEL_W-1:0] sel;
        logic             pwm_hit;
        logic             raw;
        assign sel     = pin_pwm_sel[p*SEL_W +: SEL_W];
        assign pwm_hit = (int'(sel) < N_PWM) ? pwm_chg[sel] : 1'b0;
        assign raw     = pin_pwm_en[p] ? pwm_hit : (gpio_s[p] ^ gpio_prev[p]);
        assign evt[p]  = raw & ~int_mask[p];
    end
endmodule

// File: rtl/mcig_status.sv
// Sticky per-pin status register with clear-on-read and the gated
// active-low interrupt. A read clears only the bits it returned. An
// event in the read cycle is merged after the clear.
module mcig_status #(
    parameter int N_PIN = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] evt,
    input  logic             stat_rd,
    input  logic             irq_en,
    output logic [N_PIN-1:0] status,
    output logic             irq_n
);
    // Latch events; a read strobe wipes the old bits at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (stat_rd ? '0 : status) | evt;
    end

    // Interrupt line: low while enabled and any bit is pending.
    assign irq_n = ~(irq_en & (|status));

    a_r1_set_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((status & $past(status)) == $past(status)));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && evt == '0) |=> (status == '0));

    a_r7_read_releases_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && evt == '0) |=> irq_n);
endmodule

// File: rtl/mcig_top.sv
// Masked change interrupt generator: synchronises the pins, detects masked
// changes from GPIO levels or slow-clocked PWM channels, and latches them
// into a clear-on-read status with an active-low interrupt.
// Assumes synchronous active-low reset held for at least three cycles.
module mcig_top
    import mcig_pkg::*;
#(
    parameter int N_PIN = 20,
    parameter int N_PWM = 4,
    parameter int SEL_W = (N_PWM > 1) ? $clog2(N_PWM) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PIN-1:0]           gpio_in,
    input  logic [N_PIN-1:0]           int_mask,
    input  logic [N_PIN-1:0]           pin_pwm_en,
    input  logic [N_PIN*SEL_W-1:0]     pin_pwm_sel,
    input  logic [N_PWM-1:0]           pwm_out,
    input  logic [N_PWM*CLK_SRC_W-1:0] pwm_clk_src,
    input  logic                       irq_en,
    input  logic                       stat_rd,
    output logic [N_PIN-1:0]           stat_rdata,
    output logic                       irq_n
);
    logic [N_PIN-1:0] gpio_s;
    logic [N_PIN-1:0] evt;
    logic [N_PIN-1:0] status;

    mcig_sync2 #(.WIDTH(N_PIN)) u_sync (
        .clk (clk),
        .d   (gpio_in),
        .q   (gpio_s)
    );

    mcig_change_detect #(.N_PIN(N_PIN), .N_PWM(N_PWM), .SEL_W(SEL_W)) u_detect (
        .clk         (clk),
        .gpio_s      (gpio_s),
        .int_mask    (int_mask),
        .pin_pwm_en  (pin_pwm_en),
        .pin_pwm_sel (pin_pwm_sel),
        .pwm_out     (pwm_out),
        .pwm_clk_src (pwm_clk_src),
        .evt         (evt)
    );

    mcig_status #(.N_PIN(N_PIN)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .stat_rd (stat_rd),
        .irq_en  (irq_en),
        .status  (status),
        .irq_n   (irq_n)
    );

    // Status is read directly from the latched register.
    assign stat_rdata = status;

    a_r2_masked_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & $past(int_mask)) == '0));
endmodule

// File: tb/mcig_top_test.sv
`timescale 1ns/1ps
module mcig_top_test;
    localparam int NP = 20;
    localparam int NW = 4;
    localparam int SW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     gpio_in = '0;
    logic [NP-1:0]     int_mask = '0;
    logic [NP-1:0]     pin_pwm_en;
    logic [NP*SW-1:0]  pin_pwm_sel;
    logic [NW-1:0]     pwm_out = '0;
    logic [NW*3-1:0]   pwm_clk_src;
    logic              irq_en = 1'b0;
    logic              stat_rd = 1'b0;
    logic [NP-1:0]     stat_rdata;
    logic              irq_n;

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    mcig_top #(.N_PIN(NP), .N_PWM(NW)) uut (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .int_mask(int_mask),
        .pin_pwm_en(pin_pwm_en), .pin_pwm_sel(pin_pwm_sel), .pwm_out(pwm_out),
        .pwm_clk_src(pwm_clk_src), .irq_en(irq_en), .stat_rd(stat_rd),
        .stat_rdata(stat_rdata), .irq_n(irq_n)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Read strobe: sample data inside the strobe cycle, release after the edge.
    task automatic do_read(output logic [NP-1:0] val);
        stat_rd = 1'b1;
        #1 val = stat_rdata;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [NP-1:0] v;
        chk(stat_rdata, 0, "R8 status after reset");
        chk(irq_n, 1, "R8 irq_n after reset");
        tick(4);
        do_read(v);
        chk(v, 0, "R8 reset-time levels not counted");
    endtask

    task automatic t_gpio;
        logic [NP-1:0] v;
        gpio_in[5] = 1'b1;
        tick(2);
        chk(stat_rdata, 0, "R1 not set before third edge");
        tick(1);
        chk(stat_rdata, 32'h20, "R1 rising edge sets bit");
        chk(irq_n, 0, "R7 irq low with pending bit");
        do_read(v);
        chk(stat_rdata, 0, "R6 cleared after read");
        chk(irq_n, 1, "R6 irq released after read");
        gpio_in[5] = 1'b0;
        tick(3);
        chk(stat_rdata, 32'h20, "R1 falling edge sets bit");
        do_read(v);
        gpio_in[0] = 1'b1;
        gpio_in[15] = 1'b1;
        tick(3);
        chk(stat_rdata, 32'h8001, "R1 two pins at once");
        do_read(v);
    endtask

    task automatic t_mask;
        logic [NP-1:0] v;
        int_mask[7] = 1'b1;
        gpio_in[7] = 1'b1;
        tick(4);
        do_read(v);
        chk(v, 0, "R2 masked pin ignored");
        int_mask[7] = 1'b0;
        gpio_in[7] = 1'b0;
        tick(3);
        chk(stat_rdata, 32'h80, "R2 unmasked pin reports");
        do_read(v);
    endtask

    task automatic t_pwm_slow;
        logic [NP-1:0] v;
        pwm_out[0] = 1'b1;
        tick(1);
        chk(stat_rdata, 32'h10000, "R3 slow PWM toggle after one edge");
        do_read(v);
        gpio_in[16] = 1'b1;
        tick(4);
        chk(stat_rdata, 0, "R3 gpio change on PWM pin ignored");
        pwm_out[2] = 1'b1;
        tick(2);
        do_read(v);
        pwm_out[2] = 1'b0;
        tick(1);
        chk(stat_rdata, 32'h40000, "R3 slow PWM falling toggle");
        do_read(v);
    endtask

    task automatic t_pwm_fast;
        logic [NP-1:0] v;
        pwm_out[1] = 1'b1;
        pwm_out[3] = 1'b1;
        tick(1);
        pwm_out[1] = 1'b0;
        tick(3);
        do_read(v);
        chk(v, 0, "R4 faster-clock PWM ignored");
    endtask

    task automatic t_sticky;
        logic [NP-1:0] v;
        pwm_out[0] = 1'b0;
        tick(10);
        chk(stat_rdata, 32'h10000, "R5 bit held with no activity");
        chk(irq_n, 0, "R5 irq held");
        do_read(v);
        chk(v, 32'h10000, "R5 read returns held bit");
    endtask

    task automatic t_collision;
        logic [NP-1:0] v;
        pwm_out[0] = 1'b1;
        tick(1);
        stat_rd = 1'b1;
        pwm_out[2] = 1'b1;
        #1 v = stat_rdata;
        @(negedge clk);
        stat_rd = 1'b0;
        chk(v, 32'h10000, "R6 read returns old bits");
        chk(stat_rdata, 32'h40000, "R6 same-cycle event kept");
        do_read(v);
        chk(v, 32'h40000, "R6 kept event in next read");
    endtask

    task automatic t_enable;
        logic [NP-1:0] v;
        pwm_out[2] = 1'b0;
        tick(1);
        irq_en = 1'b0;
        #1;
        chk(irq_n, 1, "R7 disabled irq high");
        chk(stat_rdata, 32'h40000, "R7 status kept while disabled");
        tick(1);
        irq_en = 1'b1;
        #1;
        chk(irq_n, 0, "R7 re-enabled irq low");
        tick(1);
        do_read(v);
    endtask

    initial begin
        pin_pwm_en  = '0;
        pin_pwm_sel = '0;
        for (int p = 16; p < 20; p++) begin
            pin_pwm_en[p] = 1'b1;
            pin_pwm_sel[p*SW +: SW] = SW'(p - 16);
        end
        pwm_clk_src = {3'd0, 3'd4, 3'd1, 3'd4};
        gpio_in[3] = 1'b1;
        tick(5);
        rst_n = 1'b1;
        irq_en = 1'b1;
        tick(1);
        t_reset();
        t_gpio();
        t_mask();
        t_pwm_slow();
        t_pwm_fast();
        t_sticky();
        t_collision();
        t_enable();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule